// File: doc/BRIEF.md
# I2S Slave Frame-Sync Gate

This block sits between an external audio codec that masters an I2S bus and a synchronous serial port that frames each word with a one-clock frame-sync pulse. The port would otherwise start a word on every pulse. The gate decides which pulses reach the port. When the block is enabled in slave mode, it drops a pulse in two cases. The first is when the left/right tag of the word at the head of the transmit FIFO disagrees with the channel the codec is asking for. The second is when the transmit FIFO is empty.

After an underrun is seen, the gate forces zeros into the serial-data input of the downstream frame delay pipe. Bits already in the pipe drain out first, and known silence follows them. The underrun ends on the first pulse that finds the FIFO non-empty with a matching tag. In master mode, or when the block is disabled, pulses and data pass through untouched.

The expected channel is the word-select level captured on the bit-clock edge before the pulse slot. The gated pulse is registered, so it appears one bit clock after the request and is exactly one clock wide.

Top module: `i2s_fsync_gate`

## Requirements
- R1: During and right after reset, fsOut is 0, and pipeDataIn equals serDataIn because no underrun is pending.
- R2: The block is active when enable=1 and slaveMode=1. While active, a request (fsReq=1) with txEmpty=0 and txTag equal to the expected channel gives fsOut=1 on the next cycle. The expected channel is the wordSel value sampled at the previous rising edge. Channel coding is 0 for left and 1 for right, on both wordSel and txTag.
- R3: While active, a request whose txTag differs from the expected channel gives fsOut=0 on the next cycle.
- R4: While active, a request with txEmpty=1 gives fsOut=0 on the next cycle and enters underrun. From the next cycle on, pipeDataIn is forced to all zeros.
- R5: Underrun, and with it the zero forcing, persists through idle cycles, through a non-empty FIFO with no request, and through mismatched requests. It ends at the first request with txEmpty=0 and a matching tag. That request's pulse is passed, and pipeDataIn follows serDataIn again from the next cycle.
- R6: With enable=1 and slaveMode=0 (master mode), fsOut is fsReq delayed by one cycle and pipeDataIn equals serDataIn, whatever the tag and empty flag.
- R7: With enable=0, fsOut is fsReq delayed by one cycle and pipeDataIn equals serDataIn.
- R8: fsOut is high only in the cycle after a cycle with fsReq high, so a single-cycle request yields a single-cycle pulse.
- R9: Leaving the active state releases the zero forcing in the same cycle and clears any pending underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Converter enable |
| slaveMode | input | 1 | 1 = codec masters the bus (gating allowed) |
| wordSel | input | 1 | Codec word-select line, 0 left, 1 right |
| fsReq | input | 1 | Ungated one-clock frame-sync request |
| txTag | input | 1 | Channel tag of the transmit FIFO head entry |
| txEmpty | input | 1 | Transmit FIFO empty flag |
| serDataIn | input | LANES | Serial data headed for the frame delay pipe |
| fsOut | output | 1 | Gated, registered frame-sync pulse to the serial port |
| pipeDataIn | output | LANES | Frame delay pipe input, zero during underrun |

## Verification
Requests are tried with every combination of word-select level and tag, so matches on both channels are told apart from mismatches in both directions. Empty-FIFO requests are tried on both channels, followed by a mismatch and then a match. This separates "the underrun persists" from "the underrun ends on any non-empty request". The same empty or mismatched inputs are then repeated in master mode and in disabled mode, which shows that the gating depends on the mode and not only on the tag and flag values. Directed cases cover reset, zero forcing while the FIFO refills without a pulse, and the immediate release of zero forcing when the block leaves slave mode.

// File: rtl/fsync_gate_pkg.sv
package fsync_gate_pkg;
  typedef struct packed {
    logic fsPass;
    logic forceZero;
  } gateStrobe_t;
endpackage

// File: rtl/fsync_gate_ctrl.sv
module fsync_gate_ctrl
  import fsync_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        slaveMode,
  input  logic        wordSel,
  input  logic        fsReq,
  input  logic        txTag,
  input  logic        txEmpty,
  output gateStrobe_t strobe
);
  logic expChan;
  logic underrun;
  logic gateActive;
  logic tagMatch;

  assign gateActive = enable && slaveMode;
  assign tagMatch   = (txTag == expChan);

  // Expected channel: word-select captured one edge before the pulse slot
  always_ff @(posedge clk) begin
    if (!rstN) expChan <= 1'b0;
    else       expChan <= wordSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !gateActive)        underrun <= 1'b0;
    else if (fsReq && txEmpty)       underrun <= 1'b1;
    else if (fsReq && tagMatch)      underrun <= 1'b0;
  end

  always_comb begin
    if (gateActive) begin
      strobe.fsPass    = fsReq && !txEmpty && tagMatch;
      strobe.forceZero = underrun;
    end else begin
      strobe.fsPass    = fsReq;
      strobe.forceZero = 1'b0;
    end
  end
endmodule

// File: rtl/fsync_gate_dp.sv
module fsync_gate_dp
  import fsync_gate_pkg::*;
#(
  parameter int LANES = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  gateStrobe_t      strobe,
  input  logic [LANES-1:0] serDataIn,
  output logic             fsOut,
  output logic [LANES-1:0] pipeDataIn
);
  always_ff @(posedge clk) begin
    if (!rstN) fsOut <= 1'b0;
    else       fsOut <= strobe.fsPass;
  end

  assign pipeDataIn = strobe.forceZero ? '0 : serDataIn;
endmodule

// File: rtl/i2s_fsync_gate.sv
module i2s_fsync_gate
  import fsync_gate_pkg::*;
#(
  parameter int LANES = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             slaveMode,
  input  logic             wordSel,
  input  logic             fsReq,
  input  logic             txTag,
  input  logic             txEmpty,
  input  logic [LANES-1:0] serDataIn,
  output logic             fsOut,
  output logic [LANES-1:0] pipeDataIn
);
  gateStrobe_t strobe;

  fsync_gate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .slaveMode(slaveMode),
    .wordSel(wordSel), .fsReq(fsReq), .txTag(txTag), .txEmpty(txEmpty),
    .strobe(strobe)
  );

  fsync_gate_dp #(.LANES(LANES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .serDataIn(serDataIn),
    .fsOut(fsOut), .pipeDataIn(pipeDataIn)
  );
endmodule

// File: rtl/i2s_fsync_gate_chk.sv
module i2s_fsync_gate_chk #(
  parameter int LANES = 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             slaveMode,
  input logic             wordSel,
  input logic             fsReq,
  input logic             txTag,
  input logic             txEmpty,
  input logic [LANES-1:0] serDataIn,
  input logic             fsOut,
  input logic [LANES-1:0] pipeDataIn
);
  logic active;
  assign active = enable && slaveMode;

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    fsOut |-> $past(fsReq));

  p_mismatch_drop_r3: assert property (@(posedge clk) disable iff (!rstN)
    (active && fsReq && $past(rstN) && (txTag != $past(wordSel))) |=> !fsOut);

  p_empty_drop_r4: assert property (@(posedge clk) disable iff (!rstN)
    (active && fsReq && txEmpty) |=> !fsOut);

  p_empty_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (active && fsReq && txEmpty) |=> (!(enable && slaveMode) || pipeDataIn == '0));

  p_master_pass_r6: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !slaveMode && fsReq) |=> fsOut);

  p_disabled_pass_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && fsReq) |=> fsOut);

  p_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> (pipeDataIn == serDataIn));
endmodule

bind i2s_fsync_gate i2s_fsync_gate_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/tb_i2s_fsync_gate.sv
module tb_i2s_fsync_gate;
  localparam int LANES = 1;
  logic clk = 1'b0;
  logic rstN, enable, slaveMode, wordSel, fsReq, txTag, txEmpty;
  logic [LANES-1:0] serDataIn;
  logic fsOut;
  logic [LANES-1:0] pipeDataIn;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  i2s_fsync_gate #(.LANES(LANES)) dut (.*);

  // fields: en, slave, ws, tag, empty, expFs, expData(serDataIn=1), req
  localparam int NV = 14;
  localparam logic [7:0][NV-1:0] VEC_UNUSED = '0;
  typedef struct packed {
    logic en; logic sl; logic ws; logic tag; logic emp; logic fs; logic dat; logic [3:0] req;
  } vec_t;
  localparam vec_t VEC [NV] = '{
    '{1,1,0,0,0,1,1,4'd2},  // R2 left match
    '{1,1,1,1,0,1,1,4'd2},  // R2 right match
    '{1,1,1,0,0,0,1,4'd3},  // R3 mismatch
    '{1,1,0,1,0,0,1,4'd3},  // R3 mismatch
    '{1,1,0,0,1,0,0,4'd4},  // R4 empty
    '{1,1,1,1,1,0,0,4'd4},  // R4 empty again
    '{1,1,1,0,0,0,0,4'd5},  // R5 mismatch keeps underrun
    '{1,1,1,1,0,1,1,4'd5},  // R5 match exits
    '{1,0,0,1,1,1,1,4'd6},  // R6 master ignores empty/mismatch
    '{1,0,1,0,0,1,1,4'd6},  // R6 master mismatch
    '{0,1,1,0,1,1,1,4'd7},  // R7 disabled
    '{0,0,0,1,0,1,1,4'd7},  // R7 disabled
    '{1,1,0,0,1,0,0,4'd4},  // R4 enter underrun
    '{1,0,0,0,0,1,1,4'd9}   // R9 master clears underrun
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runVec(input vec_t v);
    @(negedge clk);
    enable = v.en; slaveMode = v.sl; wordSel = v.ws; fsReq = 1'b0; serDataIn = '1;
    @(negedge clk);
    check("R8", 32'(fsOut), 32'd0);
    fsReq = 1'b1; txTag = v.tag; txEmpty = v.emp;
    @(negedge clk);
    fsReq = 1'b0;
    check($sformatf("R%0d", v.req), 32'(fsOut), 32'(v.fs));
    check($sformatf("R%0d", v.req), 32'(pipeDataIn), 32'(v.dat));
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; enable = 1'b1; slaveMode = 1'b1; wordSel = 1'b0; fsReq = 1'b1;
    txTag = 1'b0; txEmpty = 1'b1; serDataIn = '1;
    repeat (3) @(negedge clk);
    check("R1", 32'(fsOut), 32'd0);
    fsReq = 1'b0; rstN = 1'b1;
    @(negedge clk);
    check("R1", 32'(fsOut), 32'd0);
    check("R1", 32'(pipeDataIn), 32'd1);

    for (int i = 0; i < NV; i++) runVec(VEC[i]);

    // R5: underrun held while FIFO refills with no request
    enable = 1'b1; slaveMode = 1'b1;
    runVec('{1,1,1,1,1,0,0,4'd4});
    txEmpty = 1'b0;
    repeat (3) @(negedge clk);
    check("R5", 32'(pipeDataIn), 32'd0);
    serDataIn = '0;
    @(negedge clk);
    check("R5", 32'(pipeDataIn), 32'd0);
    serDataIn = '1;

    // R9: dropping enable releases zero forcing in the same cycle
    enable = 1'b0;
    #1;
    check("R9", 32'(pipeDataIn), 32'd1);
    @(negedge clk);
    enable = 1'b1;
    #1;
    check("R9", 32'(pipeDataIn), 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule